// File: doc/BRIEF.md
# Single-Step Non-Restoring Divide Unit

This block performs one iteration of a one-bit non-restoring division. A processor divides by issuing the step again and again in software. Each step takes a divisor, a partial remainder and three status flags, and produces the next partial remainder and flags. The add-or-subtract choice and the carry or borrow of each step are folded into the quotient-sign flag (Q), the divisor-sign flag (M) and the transfer flag (T). After each step, T holds the new quotient bit.

Two setup operations prepare the flags before a run of steps. The signed setup takes Q from the sign of the remainder, M from the sign of the divisor, and T from their exclusive OR. The unsigned setup clears all three flags. Every operation is computed in combinational logic and captured in output registers on a single valid strobe, so the remainder and the flags change on the same clock edge. A packed status word shows the three flags at fixed bit positions.

Top module: `divstep_unit`

## Requirements
- R1: After reset, `rem_out`, `q_out`, `m_out`, `t_out` and `stat_out` are all zero.
- R2: With `valid` high and `op` = 2'b00 (unsigned setup), the next edge clears Q, M and T and loads `rem_out` with `rem_in` unchanged.
- R3: With `valid` high and `op` = 2'b01 (signed setup), the next edge sets Q to bit 31 of `rem_in`, sets M to bit 31 of `dvs_in`, sets T to Q XOR M, and loads `rem_out` with `rem_in`.
- R4: A step (`op` = 2'b10) shifts `rem_in` left by one bit and places the incoming `t_in` at bit 0 before the arithmetic.
- R5: A step subtracts `dvs_in` from the shifted remainder when `q_in` equals `m_in`, and adds `dvs_in` otherwise. The 32-bit result, modulo 2^32, appears on `rem_out`.
- R6: After a step, Q is bit 31 of `rem_in` before the shift, XOR `m_in`, XOR the flag. The flag is the borrow on a subtract (result greater than the shifted value) or the carry on an add (result less than the shifted value).
- R7: After a step, T is 1 exactly when the new Q equals M.
- R8: A step leaves M equal to `m_in`.
- R9: When `valid` is low, or when `op` = 2'b11, all outputs keep their previous values.
- R10: `stat_out` carries Q at bit 8, M at bit 9 and T at bit 0, with every other bit zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid | input | 1 | Strobe that captures the selected operation |
| op | input | 2 | 00 unsigned setup, 01 signed setup, 10 step, 11 no operation |
| dvs_in | input | 32 | Divisor |
| rem_in | input | 32 | Partial remainder |
| q_in | input | 1 | Current Q flag |
| m_in | input | 1 | Current M flag |
| t_in | input | 1 | Current T flag |
| rem_out | output | 32 | Registered new partial remainder |
| q_out | output | 1 | Registered Q flag |
| m_out | output | 1 | Registered M flag |
| t_out | output | 1 | Registered T flag (quotient bit after a step) |
| stat_out | output | 32 | Packed status word |

## Verification
Directed steps are applied with all four combinations of incoming Q and M, so that both the subtract path and the add path are taken. In each path, operands are chosen to produce and to avoid a carry or borrow, which separates the Q rule from a plain sign copy. Edge remainders such as 0x80000000 and 0xFFFFFFFF, together with a zero divisor, test the bit shifted out and the wrap modulo 2^32. A long run of pseudo-random operations, with idle cycles and the no-operation code mixed in, is compared against an independent model. That model detects borrow by comparing magnitudes, while the design takes it from a wide adder.

// File: rtl/divstep_pkg.sv
package divstep_pkg;
   typedef enum logic [1:0] {
      OP_CLR  = 2'b00,
      OP_SGN  = 2'b01,
      OP_STEP = 2'b10,
      OP_NONE = 2'b11
   } dstep_op_e;
endpackage

// File: rtl/divstep_setup.sv
module divstep_setup #(
   parameter int W = 32
) (
   input  logic [W-1:0] dvs,
   input  logic [W-1:0] rem,
   input  logic         signed_mode,
   output logic         q_nx,
   output logic         m_nx,
   output logic         t_nx
);
   localparam int MSB = W - 1;

   always_comb begin
      if (signed_mode) begin
         q_nx = rem[MSB];
         m_nx = dvs[MSB];
         t_nx = rem[MSB] ^ dvs[MSB];
      end else begin
         q_nx = 1'b0;
         m_nx = 1'b0;
         t_nx = 1'b0;
      end
   end
endmodule

// File: rtl/divstep_core.sv
module divstep_core #(
   parameter int W = 32
) (
   input  logic [W-1:0] dvs,
   input  logic [W-1:0] rem,
   input  logic         q_in,
   input  logic         m_in,
   input  logic         t_in,
   output logic [W-1:0] rem_nx,
   output logic         q_nx,
   output logic         t_nx
);
   localparam int MSB = W - 1;

   logic [W-1:0] shifted;
   logic [W:0]   wide;
   logic         do_sub;
   logic         cy;
   logic         out_msb;

   assign out_msb = rem[MSB];
   assign shifted = {rem[MSB-1:0], t_in};
   assign do_sub  = (q_in == m_in);

   always_comb begin
      if (do_sub) begin
         wide = {1'b0, shifted} - {1'b0, dvs};
         cy   = wide[W];
      end else begin
         wide = {1'b0, shifted} + {1'b0, dvs};
         cy   = wide[W];
      end
   end

   assign rem_nx = wide[W-1:0];
   assign q_nx   = out_msb ^ m_in ^ cy;
   assign t_nx   = (q_nx == m_in);
endmodule

// File: rtl/divstep_stat.sv
module divstep_stat #(
   parameter int SW    = 32,
   parameter int Q_POS = 8,
   parameter int M_POS = 9,
   parameter int T_POS = 0
) (
   input  logic          q,
   input  logic          m,
   input  logic          t,
   output logic [SW-1:0] word
);
   generate
      if (Q_POS >= SW || M_POS >= SW || T_POS >= SW) begin : g_bad_pos
         $error("flag position outside status word");
      end
      if (Q_POS == M_POS || Q_POS == T_POS || M_POS == T_POS) begin : g_dup_pos
         $error("flag positions must be distinct");
      end
      for (genvar i = 0; i < SW; i++) begin : g_bit
         if (i == Q_POS) begin : g_q
            assign word[i] = q;
         end else if (i == M_POS) begin : g_m
            assign word[i] = m;
         end else if (i == T_POS) begin : g_t
            assign word[i] = t;
         end else begin : g_z
            assign word[i] = 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/divstep_unit.sv
module divstep_unit
   import divstep_pkg::*;
#(
   parameter int W     = 32,
   parameter int SW    = 32,
   parameter int Q_POS = 8,
   parameter int M_POS = 9,
   parameter int T_POS = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          valid,
   input  logic [1:0]    op,
   input  logic [W-1:0]  dvs_in,
   input  logic [W-1:0]  rem_in,
   input  logic          q_in,
   input  logic          m_in,
   input  logic          t_in,
   output logic [W-1:0]  rem_out,
   output logic          q_out,
   output logic          m_out,
   output logic          t_out,
   output logic [SW-1:0] stat_out
);
   localparam int MSB = W - 1;

   generate
      if (W < 2) begin : g_bad_w
         $error("datapath width must be at least 2");
      end
   endgenerate

   dstep_op_e    op_e;
   logic         su_q, su_m, su_t;
   logic [W-1:0] st_rem;
   logic         st_q, st_t;

   assign op_e = dstep_op_e'(op);

   divstep_setup #(.W(W)) u_setup (
      .dvs(dvs_in), .rem(rem_in), .signed_mode(op_e == OP_SGN),
      .q_nx(su_q), .m_nx(su_m), .t_nx(su_t)
   );

   divstep_core #(.W(W)) u_core (
      .dvs(dvs_in), .rem(rem_in), .q_in(q_in), .m_in(m_in), .t_in(t_in),
      .rem_nx(st_rem), .q_nx(st_q), .t_nx(st_t)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_out <= '0;
         q_out   <= 1'b0;
         m_out   <= 1'b0;
         t_out   <= 1'b0;
      end else if (valid) begin
         unique case (op_e)
            OP_CLR, OP_SGN: begin
               rem_out <= rem_in;
               q_out   <= su_q;
               m_out   <= su_m;
               t_out   <= su_t;
            end
            OP_STEP: begin
               rem_out <= st_rem;
               q_out   <= st_q;
               m_out   <= m_in;
               t_out   <= st_t;
            end
            default: ;
         endcase
      end
   end

   divstep_stat #(.SW(SW), .Q_POS(Q_POS), .M_POS(M_POS), .T_POS(T_POS)) u_stat (
      .q(q_out), .m(m_out), .t(t_out), .word(stat_out)
   );

   // R2
   setup_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && op == 2'b00) |=> (!q_out && !m_out && !t_out && rem_out == $past(rem_in)));

   // R3
   setup_sgn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && op == 2'b01) |=> (q_out == $past(rem_in[MSB]) && m_out == $past(dvs_in[MSB])
                                  && t_out == (q_out ^ m_out)));

   // R4
   step_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && op == 2'b10) |=> (rem_out[0] == $past(t_in ^ dvs_in[0])));

   // R7
   step_tbit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && op == 2'b10) |=> (t_out == (q_out == m_out)));

   // R8
   step_keep_m_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && op == 2'b10) |=> (m_out == $past(m_in)));

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid || op == 2'b11) |=> ($stable(rem_out) && $stable(q_out) && $stable(m_out) && $stable(t_out)));

   // R10
   stat_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_out[Q_POS] == q_out && stat_out[M_POS] == m_out && stat_out[T_POS] == t_out
       && $countones(stat_out) == 32'(q_out) + 32'(m_out) + 32'(t_out)));
endmodule

// File: tb/sim_divstep_unit.sv
module sim_divstep_unit;
   localparam int CLK_NS = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid = 1'b0;
   logic [1:0]  op = 2'b11;
   logic [31:0] dvs_in = '0, rem_in = '0;
   logic        q_in = 1'b0, m_in = 1'b0, t_in = 1'b0;
   logic [31:0] rem_out, stat_out;
   logic        q_out, m_out, t_out;

   int checks = 0;
   int failures = 0;

   logic [34:0] exp_q[$];
   int          kind_q[$];
   logic [34:0] model_st = '0;
   logic        armed = 1'b0;

   always #(CLK_NS/2) clk = ~clk;

   divstep_unit u0 (
      .clk(clk), .rst_n(rst_n), .valid(valid), .op(op),
      .dvs_in(dvs_in), .rem_in(rem_in), .q_in(q_in), .m_in(m_in), .t_in(t_in),
      .rem_out(rem_out), .q_out(q_out), .m_out(m_out), .t_out(t_out), .stat_out(stat_out)
   );

   function automatic logic [34:0] ref_step(input logic [1:0] o, input logic [31:0] d,
         input logic [31:0] r, input logic qi, input logic mi, input logic ti);
      logic [31:0] sh, res;
      logic fl, qn;
      case (o)
         2'b00: return {r, 3'b000};
         2'b01: return {r, r[31], d[31], r[31] ^ d[31]};
         default: begin
            sh = {r[30:0], ti};
            if (qi == mi) begin res = sh - d; fl = (res > sh); end
            else          begin res = sh + d; fl = (res < sh); end
            qn = r[31] ^ mi ^ fl;
            return {res, qn, mi, (qn == mi)};
         end
      endcase
   endfunction

   function automatic string req_of(input int k);
      case (k)
         1: return "R2";
         2: return "R3";
         3: return "R5/R6/R7/R8";
         default: return "R9";
      endcase
   endfunction

   task automatic drive(input logic v, input logic [1:0] o, input logic [31:0] d,
         input logic [31:0] r, input logic qi, input logic mi, input logic ti);
      @(negedge clk);
      valid = v; op = o; dvs_in = d; rem_in = r; q_in = qi; m_in = mi; t_in = ti;
      if (v && o != 2'b11) model_st = ref_step(o, d, r, qi, mi, ti);
      exp_q.push_back(model_st);
      kind_q.push_back((v && o != 2'b11) ? int'(o) + 1 : 0);
   endtask

   always @(posedge clk) armed <= (exp_q.size() != 0);

   always @(negedge clk) begin
      if (armed && exp_q.size() != 0) begin
         logic [34:0] e;
         int k;
         e = exp_q.pop_front();
         k = kind_q.pop_front();
         checks++;
         if ({rem_out, q_out, m_out, t_out} !== e) begin
            failures++;
            $display("FAIL %s: rem=%h q=%b m=%b t=%b expected rem=%h q=%b m=%b t=%b",
                     req_of(k), rem_out, q_out, m_out, t_out, e[34:3], e[2], e[1], e[0]);
         end
         checks++; // R10
         if (stat_out !== ((32'(e[2]) << 8) | (32'(e[1]) << 9) | 32'(e[0]))) begin
            failures++;
            $display("FAIL R10: stat=%h expected q@8 m@9 t@0 from %b%b%b", stat_out, e[2], e[1], e[0]);
         end
      end
   end

   initial begin
      #(CLK_NS * 200000);
      failures++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [31:0] a, b;
      logic [1:0]  o;
      repeat (3) @(negedge clk);
      // R1: reset state
      checks++;
      if (rem_out !== '0 || q_out !== 1'b0 || m_out !== 1'b0 || t_out !== 1'b0 || stat_out !== '0) begin
         failures++;
         $display("FAIL R1: rem=%h q=%b m=%b t=%b stat=%h expected all zero",
                  rem_out, q_out, m_out, t_out, stat_out);
      end
      rst_n = 1'b1;
      // R3 signed setup, both sign mixes
      drive(1, 2'b01, 32'h8000_0001, 32'h1234_5678, 0, 0, 0);
      drive(1, 2'b01, 32'h0000_0007, 32'hF000_0000, 0, 0, 0);
      drive(1, 2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0);
      // R2 unsigned setup after flags set
      drive(1, 2'b00, 32'hFFFF_FFFF, 32'hDEAD_BEEF, 1, 1, 1);
      // R4/R5/R6 subtract path, borrow and no borrow
      drive(1, 2'b10, 32'h0000_0001, 32'h8000_0000, 0, 0, 1);
      drive(1, 2'b10, 32'h0000_0005, 32'h0000_0001, 0, 0, 0);
      drive(1, 2'b10, 32'h8000_0000, 32'h7FFF_FFFF, 1, 1, 1);
      // R5/R6 add path, carry and no carry
      drive(1, 2'b10, 32'h0000_0001, 32'hFFFF_FFFF, 1, 0, 1);
      drive(1, 2'b10, 32'h0000_0003, 32'h0000_0010, 0, 1, 0);
      drive(1, 2'b10, 32'h0000_0000, 32'hC000_0000, 1, 0, 0);
      // R9: idle and no-operation code hold outputs
      drive(0, 2'b10, 32'h1111_1111, 32'h2222_2222, 1, 0, 1);
      drive(1, 2'b11, 32'h3333_3333, 32'h4444_4444, 0, 1, 1);
      // unsigned 32-step division 1000 / 7 chained through the outputs
      drive(1, 2'b00, 32'd7, 32'd0, 0, 0, 0);
      begin
         logic [31:0] r, quo;
         logic qf, mf, tf;
         logic [34:0] s;
         r = 32'd0; qf = 0; mf = 0; tf = 0; quo = 32'd1000;
         for (int i = 0; i < 32; i++) begin
            tf = quo[31]; quo = quo << 1;
            s = ref_step(2'b10, 32'd7 << 0, r, qf, mf, tf);
            drive(1, 2'b10, 32'd7, r, qf, mf, tf);
            r = s[34:3]; qf = s[2]; mf = s[1];
            quo[0] = s[0];
         end
         checks++; // R7: quotient bits from T
         if (quo !== 32'd142) begin
            failures++;
            $display("FAIL R7: chained quotient=%0d expected=142", quo);
         end
      end
      // random mix
      for (int i = 0; i < 400; i++) begin
         a = $urandom; b = $urandom; o = 2'($urandom);
         drive(1'($urandom_range(0, 4) != 0), o, a, b, 1'($urandom), 1'($urandom), 1'($urandom));
      end
      drive(0, 2'b11, '0, '0, 0, 0, 0);
      repeat (3) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule